// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-line general-purpose I/O port controlled through a simple 32-bit register bus. Software sets an output value and a per-line direction. It can change individual output bits with write-one set and clear addresses, so no read-modify-write is needed. It reads the synchronized state of the input pins.

Every line can raise an interrupt. Three per-line registers select the trigger. The sense bit picks edge or level. The polarity bit picks rising/high or falling/low. The dual-edge bit makes both edges count and overrides polarity. A trigger on an enabled line latches a sticky status bit. Software clears that bit by writing one to the clear address. Status bits that are not masked are ORed into a single interrupt output.

Pull control and debounce are not implemented. Their four registers only hold the values written to them.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every writable register and the interrupt status read 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: The output register (0x00) and the direction register (0x08) read back the value written. `pin_out` follows the output register. `pin_oe` follows direction: bit 1 drives line n as an output. `pin_oe` changes only on a write to 0x08.
- R3: A write to 0x10 sets every output bit written as 1. A write to 0x14 clears every output bit written as 1. Bits written as 0 keep their value.
- R4: Address 0x04 returns the pin state through a two-flop synchronizer. A pin change first appears on the second read cycle after the clock edge that samples it.
- R5: When a line's sense bit (0x34) is 0 and its dual-edge bit (0x38) is 0, polarity bit (0x3C) 0 triggers on a rising edge and polarity bit 1 triggers on a falling edge. With the interrupt line unmasked, `irq` rises on the third clock edge after the pin changes.
- R6: With the sense bit 0 and the dual-edge bit 1, both edges trigger, whatever the polarity bit is.
- R7: With the sense bit 1, polarity 0 triggers while the pin is high and polarity 1 triggers while it is low. If the level is still active, a clear leaves the status bit 0 for one cycle and it sets again on the following edge.
- R8: Writing 1 to a bit of 0x30 clears that status bit (read at 0x24). Bits written as 0 are untouched.
- R9: A status bit sets only while its enable bit (0x20) is 1.
- R10: `irq` is the OR of the status bits whose mask bit (0x2C) is 0. A masked line still records status.
- R11: Reads of 0x10, 0x14, 0x30 and of unmapped offsets return 0. Writes to 0x04, 0x24 and unmapped offsets change nothing.
- R12: The pull-enable (0x18), pull-type (0x1C), debounce-enable (0x40) and debounce-prescale (0x44) registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | 32 | Input pin levels |
| pin_out | output | 32 | Output pin values |
| pin_oe | output | 32 | Per-line output enable |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes commit on the edge that ends the access cycle, so the next read sees them. Reads are combinational and are sampled one time unit after the address is driven at a falling edge. A pin change reaches the input register after two rising edges and reaches status and `irq` after three. The bench checks both sides of each boundary: the cycle before the value is due and the cycle it arrives. For the level re-set after a clear, the bench samples status in the cycle right after the clear commits, expecting 0, and again one cycle later, expecting it set.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int LINES = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] pin_in,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_OUT  = 'h00;
  localparam logic [AW-1:0] A_IN   = 'h04;
  localparam logic [AW-1:0] A_DIR  = 'h08;
  localparam logic [AW-1:0] A_SET  = 'h10;
  localparam logic [AW-1:0] A_CLR  = 'h14;
  localparam logic [AW-1:0] A_PEN  = 'h18;
  localparam logic [AW-1:0] A_PTY  = 'h1C;
  localparam logic [AW-1:0] A_IEN  = 'h20;
  localparam logic [AW-1:0] A_STAT = 'h24;
  localparam logic [AW-1:0] A_MSK  = 'h2C;
  localparam logic [AW-1:0] A_ICLR = 'h30;
  localparam logic [AW-1:0] A_SNS  = 'h34;
  localparam logic [AW-1:0] A_DUAL = 'h38;
  localparam logic [AW-1:0] A_POL  = 'h3C;
  localparam logic [AW-1:0] A_DBE  = 'h40;
  localparam logic [AW-1:0] A_DBP  = 'h44;

  logic [LINES-1:0] out_q, dir_q, pen_q, pty_q, dbe_q, dbp_q;
  logic [LINES-1:0] int_en, int_mask, int_stat, sense_q, dual_q, pol_q;
  logic [LINES-1:0] sy1, sy2, sy_prev;

  wire wr = bus_sel & bus_wr;
  wire [LINES-1:0] clr_bits = (wr && bus_addr == A_ICLR) ? bus_wdata : '0;

  wire [LINES-1:0] rise     = sy2 & ~sy_prev;
  wire [LINES-1:0] fall     = ~sy2 & sy_prev;
  wire [LINES-1:0] edge_hit = (dual_q & (rise | fall)) |
                              (~dual_q & ~pol_q & rise) |
                              (~dual_q & pol_q & fall);
  wire [LINES-1:0] lvl_hit  = sy2 ^ pol_q;
  wire [LINES-1:0] new_edge = int_en & ~sense_q & edge_hit;
  wire [LINES-1:0] new_lvl  = int_en & sense_q & lvl_hit & ~clr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1     <= '0;
      sy2     <= '0;
      sy_prev <= '0;
    end else begin
      sy1     <= pin_in;
      sy2     <= sy1;
      sy_prev <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      pen_q    <= '0;
      pty_q    <= '0;
      dbe_q    <= '0;
      dbp_q    <= '0;
      int_en   <= '0;
      int_mask <= '0;
      sense_q  <= '0;
      dual_q   <= '0;
      pol_q    <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_OUT:  out_q    <= bus_wdata;
        A_SET:  out_q    <= out_q | bus_wdata;
        A_CLR:  out_q    <= out_q & ~bus_wdata;
        A_DIR:  dir_q    <= bus_wdata;
        A_PEN:  pen_q    <= bus_wdata;
        A_PTY:  pty_q    <= bus_wdata;
        A_IEN:  int_en   <= bus_wdata;
        A_MSK:  int_mask <= bus_wdata;
        A_SNS:  sense_q  <= bus_wdata;
        A_DUAL: dual_q   <= bus_wdata;
        A_POL:  pol_q    <= bus_wdata;
        A_DBE:  dbe_q    <= bus_wdata;
        A_DBP:  dbp_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_stat <= '0;
    else        int_stat <= (int_stat & ~clr_bits) | new_edge | new_lvl;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_OUT:  bus_rdata = out_q;
        A_IN:   bus_rdata = sy2;
        A_DIR:  bus_rdata = dir_q;
        A_PEN:  bus_rdata = pen_q;
        A_PTY:  bus_rdata = pty_q;
        A_IEN:  bus_rdata = int_en;
        A_STAT: bus_rdata = int_stat;
        A_MSK:  bus_rdata = int_mask;
        A_SNS:  bus_rdata = sense_q;
        A_DUAL: bus_rdata = dual_q;
        A_POL:  bus_rdata = pol_q;
        A_DBE:  bus_rdata = dbe_q;
        A_DBP:  bus_rdata = dbp_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(int_stat & ~int_mask);
endmodule

module gpio_irq_port_chk #(
  parameter int LINES = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [LINES-1:0] bus_wdata,
  input logic [LINES-1:0] pin_out,
  input logic [LINES-1:0] pin_oe,
  input logic             irq,
  input logic [LINES-1:0] stat,
  input logic [LINES-1:0] ien,
  input logic [LINES-1:0] imask
);
  localparam logic [AW-1:0] C_DIR  = 'h08;
  localparam logic [AW-1:0] C_SET  = 'h10;
  localparam logic [AW-1:0] C_CLR  = 'h14;
  localparam logic [AW-1:0] C_ICLR = 'h30;

  wire wr = bus_sel & bus_wr;

  // R9
  stat_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat) & ~$past(ien)) == '0));

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == C_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == C_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == C_ICLR) |=> ((stat & $past(bus_wdata) & ~$past(ien)) == '0));

  // R10
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '1) |-> !irq);

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && bus_addr == C_DIR) |=> $stable(pin_oe));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.LINES(LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .stat(int_stat), .ien(int_en), .imask(int_mask)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        irq;
  int errors = 0, checks = 0;
  bit done = 0;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  // {write, requirement, address, data-or-expected}
  localparam int NV = 28;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 4'd2,  8'h00, 32'hA5A5_0000},  // R2
    {1'b0, 4'd2,  8'h00, 32'hA5A5_0000},  // R2
    {1'b1, 4'd2,  8'h08, 32'h0000_FFFF},  // R2
    {1'b0, 4'd2,  8'h08, 32'h0000_FFFF},  // R2
    {1'b1, 4'd3,  8'h10, 32'h0000_00FF},  // R3
    {1'b0, 4'd3,  8'h00, 32'hA5A5_00FF},  // R3
    {1'b1, 4'd3,  8'h14, 32'hA000_000F},  // R3
    {1'b0, 4'd3,  8'h00, 32'h05A5_00F0},  // R3
    {1'b0, 4'd11, 8'h10, 32'h0},          // R11
    {1'b0, 4'd11, 8'h14, 32'h0},          // R11
    {1'b0, 4'd11, 8'h30, 32'h0},          // R11
    {1'b0, 4'd11, 8'h0C, 32'h0},          // R11
    {1'b0, 4'd11, 8'hFC, 32'h0},          // R11
    {1'b1, 4'd12, 8'h18, 32'h1234_5678},  // R12
    {1'b1, 4'd12, 8'h1C, 32'h9ABC_DEF0},  // R12
    {1'b1, 4'd12, 8'h40, 32'h0F0F_0F0F},  // R12
    {1'b1, 4'd12, 8'h44, 32'h0000_0321},  // R12
    {1'b0, 4'd12, 8'h18, 32'h1234_5678},  // R12
    {1'b0, 4'd12, 8'h1C, 32'h9ABC_DEF0},  // R12
    {1'b0, 4'd12, 8'h40, 32'h0F0F_0F0F},  // R12
    {1'b0, 4'd12, 8'h44, 32'h0000_0321},  // R12
    {1'b1, 4'd11, 8'h24, 32'hFFFF_FFFF},  // R11
    {1'b0, 4'd11, 8'h24, 32'h0},          // R11
    {1'b1, 4'd11, 8'h04, 32'hFFFF_FFFF},  // R11
    {1'b0, 4'd11, 8'h04, 32'h0},          // R11
    {1'b1, 4'd11, 8'h48, 32'hFFFF_FFFF},  // R11
    {1'b0, 4'd11, 8'h48, 32'h0},          // R11
    {1'b0, 4'd11, 8'h00, 32'h05A5_00F0}   // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_sel = 0;
  endtask

  // samples in the current low phase, no edge consumed
  task automatic peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    peek(tag, a, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 'h48; a += 4) rd("R1 reg", 8'(a), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][39:32], VEC[i][31:0]);
      else rd($sformatf("R%0d vec%0d", VEC[i][43:40], i), VEC[i][39:32], VEC[i][31:0]);
    end
    check("R2 pin_out", pin_out, 32'h05A5_00F0);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);

    // R4 synchronizer latency
    @(negedge clk); pin_in = 32'h8000_0001; bus_sel = 1; bus_addr = 8'h04;
    @(negedge clk); #1 check("R4 one edge", bus_rdata, 0);
    @(negedge clk); #1 check("R4 two edges", bus_rdata, 32'h8000_0001);
    @(negedge clk); pin_in = 0; settle();

    // R5 rising on bit0, falling on bit1
    wr(8'h3C, 32'h2);
    wr(8'h20, 32'h3);
    @(negedge clk); pin_in = 32'h3;
    @(negedge clk); @(negedge clk);
    check("R5 irq before due", {31'b0, irq}, 0);
    @(negedge clk);
    check("R5 irq on third edge", {31'b0, irq}, 1);
    rd("R5 rise only", 8'h24, 32'h1);
    @(negedge clk); pin_in = 0; settle();
    rd("R5 fall added", 8'h24, 32'h3);
    // R8 w1c
    wr(8'h30, 32'h2);
    rd("R8 clear one bit", 8'h24, 32'h1);
    wr(8'h30, 32'h0);
    rd("R8 zero write", 8'h24, 32'h1);
    wr(8'h30, 32'h1);
    rd("R8 cleared", 8'h24, 32'h0);
    check("R8 irq low", {31'b0, irq}, 0);

    // R6 dual edge, polarity ignored
    wr(8'h38, 32'h4); wr(8'h3C, 32'h6); wr(8'h20, 32'h4);
    @(negedge clk); pin_in = 32'h4; settle();
    rd("R6 rise", 8'h24, 32'h4);
    wr(8'h30, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 0; settle();
    rd("R6 fall", 8'h24, 32'h4);
    wr(8'h30, 32'hFFFF_FFFF);

    // R7 level: bit3 high-active, bit4 low-active
    wr(8'h34, 32'h18); wr(8'h3C, 32'h10); wr(8'h20, 32'h18);
    settle();
    rd("R7 low active", 8'h24, 32'h10);
    @(negedge clk); pin_in = 32'h8; settle();
    rd("R7 high active", 8'h24, 32'h18);
    wr(8'h30, 32'h18);
    peek("R7 cleared one cycle", 8'h24, 32'h0);
    rd("R7 re-set", 8'h24, 32'h18);
    @(negedge clk); pin_in = 32'h10; settle();
    wr(8'h30, 32'hFFFF_FFFF);
    settle();
    rd("R7 inactive", 8'h24, 32'h0);

    // R9 disabled line
    wr(8'h20, 32'h0);
    @(negedge clk); pin_in = 32'h30; settle();
    rd("R9 no status", 8'h24, 32'h0);
    check("R9 irq", {31'b0, irq}, 0);

    // R10 mask
    wr(8'h2C, 32'h40); wr(8'h20, 32'h40);
    @(negedge clk); pin_in = 32'h70; settle();
    rd("R10 masked status", 8'h24, 32'h40);
    check("R10 masked irq", {31'b0, irq}, 0);
    wr(8'h2C, 32'h0);
    @(negedge clk);
    check("R10 unmasked irq", {31'b0, irq}, 1);
    wr(8'h30, 32'h40);
    @(negedge clk);
    check("R10 irq after clear", {31'b0, irq}, 0);

    done = 1;
    report();
  end
endmodule